// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block decides, cycle by cycle, whether a synchronous buck power stage may switch. It watches a sampled supply-voltage code, a sampled junction-temperature code, a synchronized enable and a current-limit comparator flag. It combines them into a single registered run permission for the gate-drive logic.

Three protections feed that decision. Supply lockout uses a rising threshold with a lower release point and a consecutive-sample deglitch filter, so short dips are ignored. Thermal shutdown trips at a high temperature and restarts the stage by itself once the junction has cooled through a wide hysteresis band. An over-current event seen while the low-side switch conducts latches the stage off at once. A separate persistence timer drives an active-low fault flag, and that flag drops only when the over-current condition lasts long enough. The latch and the flag clear only when enable goes low or supply lockout re-engages.

Thresholds are parameters in code units (millivolts for supply, degrees Celsius for temperature). Both filter intervals are counts of clock cycles.

Top module: `pstage_supervisor`

## Requirements
- R1: After reset, run_o=0, oc_latched_o=0, fault_n_o=1 and ot_o=0, and supply lockout is engaged.
- R2: Lockout releases at the clock edge that completes SUP_DGL consecutive samples with vcode_i strictly above UV_RISE. A code equal to UV_RISE does not count. run_o rises one edge later when the other conditions allow.
- R3: Lockout re-engages after SUP_DGL consecutive samples with vcode_i strictly below UV_RISE-UV_HYST. Codes from UV_RISE-UV_HYST up to UV_RISE leave the lockout state unchanged.
- R4: A run of fewer than SUP_DGL consecutive qualifying supply samples does not change the lockout state. The run count restarts when the condition breaks.
- R5: Sampling en_i=0 forces run_o low at the next edge.
- R6: Sampling tcode_i >= OT_TRIP sets ot_o at that edge, and run_o is low from the following edge on.
- R7: ot_o stays high while tcode_i > OT_TRIP-OT_HYST. It clears at the edge that samples tcode_i <= OT_TRIP-OT_HYST, after which switching may resume.
- R8: Sampling oc_trip_i=1 together with ls_on_i=1 sets oc_latched_o at that edge, and run_o falls one edge later. oc_trip_i with ls_on_i=0 has no effect.
- R9: oc_latched_o clears only when en_i is sampled low or supply lockout is engaged. Thermal recovery leaves it set.
- R10: fault_n_o goes low at the edge that completes OC_DGL consecutive qualified over-current samples. A shorter burst restarts the count and leaves fault_n_o high. fault_n_o returns high whenever the latch clears.
- R11: run_o is the registered AND of en_i, released lockout, no over-temperature and no over-current latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Synchronized enable |
| vcode_i | input | VW | Sampled supply code (mV) |
| tcode_i | input | TW | Sampled junction temperature (degrees C) |
| oc_trip_i | input | 1 | Current-limit comparator flag |
| ls_on_i | input | 1 | Low-side switch is conducting |
| run_o | output | 1 | Registered switching permission |
| oc_latched_o | output | 1 | Over-current latch-off state |
| fault_n_o | output | 1 | Active-low deglitched fault flag |
| ot_o | output | 1 | Over-temperature status |

## Verification
Each status register responds at the edge that samples its cause: ot_o and oc_latched_o one edge after the stimulus, lockout after SUP_DGL edges and fault_n_o after OC_DGL edges. run_o always trails those states by one further edge. The directed tests drive inputs on the falling edge and count exactly that many rising edges before sampling, so the checks look at both the edge before each transition and the edge of it. The vector table holds each stimulus for at least its longest latency before comparing.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic {
        UV_LOCKED   = 1'b0,
        UV_RELEASED = 1'b1
    } uv_state_e;

    typedef struct packed {
        logic en;
        logic uv_ok;
        logic ot;
        logic oc_latched;
    } gate_req_t;

    function automatic logic permit(input gate_req_t r);
        return r.en & r.uv_ok & ~r.ot & ~r.oc_latched;
    endfunction

endpackage

// File: rtl/pss_uvlo.sv
module pss_uvlo #(
    parameter int VW       = 13,
    parameter int UV_RISE  = 4000,
    parameter int UV_HYST  = 100,
    parameter int SUP_DGL  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vcode,
    output logic          uv_ok
);
    import pwrsup_pkg::*;

    localparam int CW = $clog2(SUP_DGL + 1);
    localparam logic [VW-1:0] RISE_C = VW'(UV_RISE);
    localparam logic [VW-1:0] FALL_C = VW'(UV_RISE - UV_HYST);
    localparam logic [CW-1:0] LAST_C = CW'(SUP_DGL - 1);

    uv_state_e     state_q;
    logic [CW-1:0] run_cnt_q;
    logic          want_flip;

    always_comb begin
        if (state_q == UV_RELEASED) want_flip = (vcode < FALL_C);
        else                        want_flip = (vcode > RISE_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= UV_LOCKED;
            run_cnt_q <= '0;
        end else if (!want_flip) begin
            run_cnt_q <= '0;
        end else if (run_cnt_q == LAST_C) begin
            run_cnt_q <= '0;
            state_q   <= (state_q == UV_RELEASED) ? UV_LOCKED : UV_RELEASED;
        end else begin
            run_cnt_q <= run_cnt_q + 1'b1;
        end
    end

    assign uv_ok = (state_q == UV_RELEASED);
endmodule

// File: rtl/pss_thermal.sv
module pss_thermal #(
    parameter int TW      = 8,
    parameter int OT_TRIP = 145,
    parameter int OT_HYST = 45
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tcode,
    output logic          ot
);
    localparam logic [TW-1:0] TRIP_C = TW'(OT_TRIP);
    localparam logic [TW-1:0] REL_C  = TW'(OT_TRIP - OT_HYST);

    logic ot_q;

    always_ff @(posedge clk) begin
        if (rst)       ot_q <= 1'b0;
        else if (ot_q) ot_q <= (tcode > REL_C);
        else           ot_q <= (tcode >= TRIP_C);
    end

    assign ot = ot_q;
endmodule

// File: rtl/pss_ocguard.sv
module pss_ocguard #(
    parameter int OC_DGL = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic ls_on,
    input  logic clear,
    output logic latched,
    output logic fault_n
);
    localparam int CW = $clog2(OC_DGL + 1);
    localparam logic [CW-1:0] LAST_C = CW'(OC_DGL - 1);

    logic          qual;
    logic          latch_q;
    logic          flag_q;
    logic [CW-1:0] cnt_q;

    assign qual = trip & ls_on;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            latch_q <= 1'b0;
            flag_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (qual) latch_q <= 1'b1;
            if (!qual) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST_C) begin
                flag_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign latched = latch_q;
    assign fault_n = ~flag_q;
endmodule

// File: rtl/pstage_supervisor.sv
module pstage_supervisor #(
    parameter int VW       = 13,
    parameter int TW       = 8,
    parameter int UV_RISE  = 4000,
    parameter int UV_HYST  = 100,
    parameter int SUP_DGL  = 64,
    parameter int OT_TRIP  = 145,
    parameter int OT_HYST  = 45,
    parameter int OC_DGL   = 30000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [VW-1:0] vcode_i,
    input  logic [TW-1:0] tcode_i,
    input  logic          oc_trip_i,
    input  logic          ls_on_i,
    output logic          run_o,
    output logic          oc_latched_o,
    output logic          fault_n_o,
    output logic          ot_o
);
    import pwrsup_pkg::*;

    logic      uv_ok;
    logic      ot;
    logic      oc_latched;
    logic      oc_clear;
    gate_req_t req;
    logic      run_q;

    pss_uvlo #(.VW(VW), .UV_RISE(UV_RISE), .UV_HYST(UV_HYST), .SUP_DGL(SUP_DGL)) u_uvlo (
        .clk(clk), .rst(rst), .vcode(vcode_i), .uv_ok(uv_ok)
    );

    pss_thermal #(.TW(TW), .OT_TRIP(OT_TRIP), .OT_HYST(OT_HYST)) u_therm (
        .clk(clk), .rst(rst), .tcode(tcode_i), .ot(ot)
    );

    assign oc_clear = ~en_i | ~uv_ok;

    pss_ocguard #(.OC_DGL(OC_DGL)) u_oc (
        .clk(clk), .rst(rst), .trip(oc_trip_i), .ls_on(ls_on_i),
        .clear(oc_clear), .latched(oc_latched), .fault_n(fault_n_o)
    );

    always_comb begin
        req.en         = en_i;
        req.uv_ok      = uv_ok;
        req.ot         = ot;
        req.oc_latched = oc_latched;
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= permit(req);
    end

    assign run_o        = run_q;
    assign oc_latched_o = oc_latched;
    assign ot_o         = ot;
endmodule

// File: rtl/pstage_supervisor_chk.sv
module pstage_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic uv_ok,
    input logic run,
    input logic oc_latched,
    input logic fault_n,
    input logic ot
);
    assert_en_low_stops_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> !run);

    assert_hot_stops_R6: assert property (@(posedge clk) disable iff (rst)
        ot |=> !run);

    assert_latch_stops_R8: assert property (@(posedge clk) disable iff (rst)
        oc_latched |=> !run);

    assert_latch_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (oc_latched && en && uv_ok) |=> oc_latched);

    assert_flag_needs_latch_R10: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> oc_latched);

    assert_all_clear_runs_R11: assert property (@(posedge clk) disable iff (rst)
        (en && uv_ok && !ot && !oc_latched) |=> run);

    assert_lockout_stops_R3: assert property (@(posedge clk) disable iff (rst)
        !uv_ok |=> !run);
endmodule

bind pstage_supervisor pstage_supervisor_chk u_chk (
    .clk(clk), .rst(rst), .en(en_i), .uv_ok(uv_ok), .run(run_o),
    .oc_latched(oc_latched_o), .fault_n(fault_n_o), .ot(ot_o)
);

// File: tb/pstage_supervisor_bench.sv
module pstage_supervisor_bench;
    localparam int VW = 13;
    localparam int TW = 8;
    localparam int SUP_DGL = 4;
    localparam int OC_DGL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [VW-1:0] vcode = '0;
    logic [TW-1:0] tcode = '0;
    logic oc = 1'b0;
    logic ls = 1'b0;
    logic run, latched, fault_n, ot;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pstage_supervisor #(.VW(VW), .TW(TW), .UV_RISE(4000), .UV_HYST(100), .SUP_DGL(SUP_DGL),
                        .OT_TRIP(145), .OT_HYST(45), .OC_DGL(OC_DGL)) u_pstage_supervisor (
        .clk(clk), .rst(rst), .en_i(en), .vcode_i(vcode), .tcode_i(tcode),
        .oc_trip_i(oc), .ls_on_i(ls), .run_o(run), .oc_latched_o(latched),
        .fault_n_o(fault_n), .ot_o(ot)
    );

    // en, vcode, tcode, oc, ls, hold, run, latched, fault_n, ot
    localparam int NV = 16;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 13'd4100, 8'd25,  1'b0, 1'b0, 5'd6,  4'b1010},  // R2 release
        {1'b1, 13'd3950, 8'd25,  1'b0, 1'b0, 5'd6,  4'b1010},  // R3 band holds
        {1'b1, 13'd3950, 8'd150, 1'b0, 1'b0, 5'd2,  4'b0011},  // R6
        {1'b1, 13'd3950, 8'd120, 1'b0, 1'b0, 5'd3,  4'b0011},  // R7 band
        {1'b1, 13'd3950, 8'd100, 1'b0, 1'b0, 5'd2,  4'b1010},  // R7 release
        {1'b1, 13'd3950, 8'd100, 1'b1, 1'b0, 5'd3,  4'b1010},  // R8 ignored
        {1'b1, 13'd3950, 8'd100, 1'b1, 1'b1, 5'd3,  4'b0110},  // R8 latch
        {1'b1, 13'd3950, 8'd100, 1'b0, 1'b0, 5'd2,  4'b0110},  // R9
        {1'b1, 13'd3950, 8'd150, 1'b0, 1'b0, 5'd2,  4'b0111},  // R9 hot
        {1'b1, 13'd3950, 8'd90,  1'b0, 1'b0, 5'd3,  4'b0110},  // R9 cooled
        {1'b0, 13'd3950, 8'd90,  1'b0, 1'b0, 5'd2,  4'b0010},  // R9 en clear
        {1'b1, 13'd3950, 8'd90,  1'b0, 1'b0, 5'd2,  4'b1010},  // R11
        {1'b1, 13'd3950, 8'd90,  1'b1, 1'b1, 5'd10, 4'b0100},  // R10
        {1'b1, 13'd3800, 8'd90,  1'b0, 1'b0, 5'd6,  4'b0010},  // R9 lockout clear
        {1'b1, 13'd4000, 8'd90,  1'b0, 1'b0, 5'd6,  4'b0010},  // R2 equal
        {1'b1, 13'd4001, 8'd90,  1'b0, 1'b0, 5'd6,  4'b1010}   // R2
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect4(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {run, latched, fault_n, ot};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: run/latch/fault_n/ot actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic expect1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; vcode = '0; tcode = 8'd25; oc = 1'b0; ls = 1'b0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic bring_up();
        en = 1'b1; vcode = 13'd4100;
        step(SUP_DGL + 1);
    endtask

    initial begin
        do_reset();
        expect4("R1", 4'b0010);

        for (int i = 0; i < NV; i++) begin
            en = VEC[i][32]; vcode = VEC[i][31:19]; tcode = VEC[i][18:11];
            oc = VEC[i][10]; ls = VEC[i][9];
            step(int'(VEC[i][8:4]));
            expect4($sformatf("R11 vector %0d", i), VEC[i][3:0]);
        end

        // R2: exact release latency
        do_reset();
        en = 1'b1; vcode = 13'd4100;
        step(SUP_DGL);
        expect1("R2 run before edge", run, 1'b0);
        step(1);
        expect1("R2 run at edge", run, 1'b1);

        // R4: short dip ignored
        vcode = 13'd3850; step(SUP_DGL - 1);
        vcode = 13'd4100; step(SUP_DGL);
        expect1("R4 dip ignored", run, 1'b1);

        // R3: long dip engages lockout
        vcode = 13'd3850; step(SUP_DGL);
        expect1("R3 run still high", run, 1'b1);
        step(1);
        expect1("R3 lockout drops run", run, 1'b0);

        // R5: enable low, one-edge latency
        vcode = 13'd4100; step(SUP_DGL + 1);
        en = 1'b0; step(1);
        expect1("R5 enable low", run, 1'b0);

        // R6: over-temperature latency
        do_reset(); bring_up();
        tcode = 8'd145; step(1);
        expect4("R6 ot set, run pending", 4'b1011);
        step(1);
        expect1("R6 run low", run, 1'b0);

        // R10: burst one short of interval, then full interval
        do_reset(); bring_up();
        oc = 1'b1; ls = 1'b1; step(1);
        expect4("R8 latch at first edge", 4'b1110);
        step(OC_DGL - 2);
        oc = 1'b0; step(1);
        expect1("R10 short burst keeps flag high", fault_n, 1'b1);
        oc = 1'b1; step(OC_DGL - 1);
        expect1("R10 restarted count", fault_n, 1'b1);
        step(1);
        expect1("R10 flag low at interval", fault_n, 1'b0);
        oc = 1'b0; ls = 1'b0; en = 1'b0; step(1);
        expect4("R10 flag released with latch", 4'b0010);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule